// File: doc/BRIEF.md
# Sized Aligned Byte-Addressable Memory

This block is a small on-chip memory in which every byte has an address of its own, while the storage is organised as rows of eight bytes. One request moves a byte, a 16-bit half, a 32-bit quantity or a full 64-bit row. A 2-bit size code selects the width. The block decides which byte lanes of a row take part in the access, moves the data onto or off those lanes, and checks that the start address is a natural multiple of the access width.

Multi-byte values are little-endian: the byte at the lowest address is the least significant one. Write data is taken right-justified from the 64-bit write bus. Read data comes back right-justified and zero-extended on the 64-bit read bus, one cycle after the request. A start address that does not divide evenly by the access width is rejected in the same cycle. A rejected write changes no byte, and a rejected read returns zero.

Top module: `sized_row_mem`

## Requirements
- R1: Size code 2'b00 moves 1 byte, 2'b01 moves 2, 2'b10 moves 4 and 2'b11 moves 8. An accepted write changes exactly the bytes from the start address up to the start address plus the width minus one. It takes them from the lowest bytes of `wdata_i`; the higher `wdata_i` bytes and every other stored byte are unaffected.
- R2: `err_o` is high in the cycle of a request exactly when the access is misaligned. Byte accesses are never misaligned. A 2-byte access is misaligned when `addr_i[0]` is set, a 4-byte access when `addr_i[1:0]` is nonzero, and an 8-byte access when `addr_i[2:0]` is nonzero.
- R3: A misaligned write leaves every stored byte unchanged.
- R4: A misaligned read still produces `rvalid_o` one cycle later, with `rdata_o` equal to zero.
- R5: Little-endian ordering. Byte k of a multi-byte access, counting from the start address, appears at `rdata_o[8k+7:8k]`, and on a write it is taken from `wdata_i[8k+7:8k]`.
- R6: `rdata_o` bits above the access width read as zero.
- R7: `rvalid_o` is high in the cycle after a read request (`req_i`=1, `we_i`=0) and low in the cycle after any other cycle.
- R8: A write takes effect at the clock edge of its request, so a read issued in the very next cycle returns the new value.
- R9: While and just after reset (`rst_ni` low), `rvalid_o` is 0 and `rdata_o` is 0.
- R10: With `req_i` low, nothing is written and `err_o` stays low, whatever `we_i`, `size_i`, `addr_i` and `wdata_i` carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset of the read register |
| req_i | input | 1 | Access request for this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| size_i | input | 2 | Access width code (00=1, 01=2, 10=4, 11=8 bytes) |
| addr_i | input | ADDR_W | Byte address of the first byte |
| wdata_i | input | 64 | Right-justified write data |
| rdata_o | output | 64 | Right-justified, zero-extended read data |
| rvalid_o | output | 1 | Read data valid (one cycle after a read request) |
| err_o | output | 1 | Misaligned request in this cycle |

## Verification
The bench first fills the whole memory with full-row writes. It then reads a known row back byte by byte, in halves and in 32-bit pieces, which separates correct little-endian lane order and zero extension from swapped or unmasked lanes. Byte, half and 32-bit writes into rows that have just been read back show whether neighbouring bytes and upper write-data bytes leak into storage. A sweep of every size against every row offset checks the alignment rule and shows that misaligned writes leave the row intact. Idle cycles driving write-like values show that nothing is stored without a request, and a long run of pseudo-random aligned accesses is compared with a byte-level model.

// File: rtl/sized_mem_pkg.sv
package sized_mem_pkg;

    localparam int ROW_BYTES = 8;
    localparam int ROW_W     = ROW_BYTES * 8;
    localparam int OFF_W     = $clog2(ROW_BYTES);
    localparam int SIZE_W    = $clog2(OFF_W + 1);

    typedef enum logic [SIZE_W-1:0] {
        SZ_B8  = 2'b00,
        SZ_B16 = 2'b01,
        SZ_B32 = 2'b10,
        SZ_B64 = 2'b11
    } acc_size_e;

    typedef struct packed {
        logic             rvalid;
        logic [ROW_W-1:0] rdata;
    } rd_state_t;

endpackage

// File: rtl/acc_align_check.sv
module acc_align_check
    import sized_mem_pkg::*;
(
    input  logic [SIZE_W-1:0]    size_i,
    input  logic [OFF_W-1:0]     off_i,
    output logic                 misaligned_o,
    output logic [ROW_BYTES-1:0] be_o
);

    logic [OFF_W:0]   nbytes;
    logic [OFF_W-1:0] low_mask;

    always_comb begin
        nbytes       = (OFF_W + 1)'(1) << size_i;
        low_mask     = OFF_W'(nbytes - 1'b1);
        misaligned_o = |(off_i & low_mask);
        for (int i = 0; i < ROW_BYTES; i++) begin
            be_o[i] = !misaligned_o
                      && (i >= int'(off_i))
                      && (i < int'(off_i) + int'(nbytes));
        end
    end

endmodule

// File: rtl/lane_steer.sv
module lane_steer
    import sized_mem_pkg::*;
(
    input  logic [SIZE_W-1:0] size_i,
    input  logic [OFF_W-1:0]  off_i,
    input  logic [ROW_W-1:0]  wdata_i,
    input  logic [ROW_W-1:0]  row_rd_i,
    output logic [ROW_W-1:0]  lane_wdata_o,
    output logic [ROW_W-1:0]  rd_just_o
);

    logic [OFF_W+2:0] bit_shift;
    logic [OFF_W:0]   nbytes;
    logic [ROW_W-1:0] shifted;

    always_comb begin
        bit_shift    = {off_i, 3'b000};
        nbytes       = (OFF_W + 1)'(1) << size_i;
        lane_wdata_o = wdata_i << bit_shift;
        shifted      = row_rd_i >> bit_shift;
        for (int i = 0; i < ROW_BYTES; i++) begin
            rd_just_o[8*i +: 8] = (i < int'(nbytes)) ? shifted[8*i +: 8] : 8'h00;
        end
    end

endmodule

// File: rtl/byte_lane_bank.sv
module byte_lane_bank #(
    parameter int ROWS  = 128,
    parameter int IDX_W = $clog2(ROWS)
) (
    input  logic             clk_i,
    input  logic             we_i,
    input  logic [IDX_W-1:0] row_i,
    input  logic [7:0]       wbyte_i,
    output logic [7:0]       rbyte_o
);

    logic [7:0] mem_q [ROWS];

    always_ff @(posedge clk_i) begin
        if (we_i) begin
            mem_q[row_i] <= wbyte_i;
        end
    end

    assign rbyte_o = mem_q[row_i];

endmodule

// File: rtl/sized_row_mem.sv
module sized_row_mem
    import sized_mem_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 req_i,
    input  logic                 we_i,
    input  logic [SIZE_W-1:0]    size_i,
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic [ROW_W-1:0]     wdata_i,
    output logic [ROW_W-1:0]     rdata_o,
    output logic                 rvalid_o,
    output logic                 err_o
);

    localparam int ROW_IDX_W = ADDR_W - OFF_W;
    localparam int ROWS      = 1 << ROW_IDX_W;

    logic [ROW_IDX_W-1:0] row_idx;
    logic [OFF_W-1:0]     row_off;
    logic                 misaligned;
    logic [ROW_BYTES-1:0] byte_en;
    logic [ROW_W-1:0]     lane_wdata;
    logic [ROW_W-1:0]     row_rd;
    logic [ROW_W-1:0]     rd_just;
    logic                 wr_fire;
    logic                 rd_fire;

    rd_state_t st_d, st_q;

    assign row_idx = addr_i[ADDR_W-1:OFF_W];
    assign row_off = addr_i[OFF_W-1:0];

    acc_align_check i_align (
        .size_i      (size_i),
        .off_i       (row_off),
        .misaligned_o(misaligned),
        .be_o        (byte_en)
    );

    lane_steer i_steer (
        .size_i      (size_i),
        .off_i       (row_off),
        .wdata_i     (wdata_i),
        .row_rd_i    (row_rd),
        .lane_wdata_o(lane_wdata),
        .rd_just_o   (rd_just)
    );

    assign wr_fire = req_i && we_i && !misaligned;
    assign rd_fire = req_i && !we_i;

    for (genvar g = 0; g < ROW_BYTES; g++) begin : g_lane
        byte_lane_bank #(
            .ROWS (ROWS),
            .IDX_W(ROW_IDX_W)
        ) i_bank (
            .clk_i  (clk_i),
            .we_i   (wr_fire && byte_en[g]),
            .row_i  (row_idx),
            .wbyte_i(lane_wdata[8*g +: 8]),
            .rbyte_o(row_rd[8*g +: 8])
        );
    end

    always_comb begin
        st_d        = st_q;
        st_d.rvalid = rd_fire;
        if (rd_fire) begin
            st_d.rdata = misaligned ? '0 : rd_just;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata_o  = st_q.rdata;
    assign rvalid_o = st_q.rvalid;
    assign err_o    = req_i && misaligned;

endmodule

// File: rtl/sized_row_mem_chk.sv
module sized_row_mem_chk
    import sized_mem_pkg::*;
(
    input logic              clk_i,
    input logic              rst_ni,
    input logic              req_i,
    input logic              we_i,
    input logic [SIZE_W-1:0] size_i,
    input logic [OFF_W-1:0]  off_i,
    input logic [ROW_W-1:0]  rdata_o,
    input logic              rvalid_o,
    input logic              err_o
);

    assert_idle_no_err_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !req_i |-> !err_o);

    assert_byte_never_err_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_i && size_i == SZ_B8) |-> !err_o);

    assert_row_off_err_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_i && size_i == SZ_B64 && off_i != '0) |-> err_o);

    assert_read_valid_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_i && !we_i) |=> rvalid_o);

    assert_no_spurious_valid_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(req_i && !we_i) |=> !rvalid_o);

    assert_bad_read_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_i && !we_i && err_o) |=> (rdata_o == '0));

    assert_byte_zero_ext_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_i && !we_i && size_i == SZ_B8) |=> (rdata_o[ROW_W-1:8] == '0));

endmodule

bind sized_row_mem sized_row_mem_chk i_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req_i),
    .we_i    (we_i),
    .size_i  (size_i),
    .off_i   (addr_i[sized_mem_pkg::OFF_W-1:0]),
    .rdata_o (rdata_o),
    .rvalid_o(rvalid_o),
    .err_o   (err_o)
);

// File: tb/test_sized_row_mem.sv
module test_sized_row_mem;

    localparam int AW    = 10;
    localparam int BYTES = 1 << AW;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        we = 1'b0;
    logic [1:0]  size = 2'b00;
    logic [AW-1:0] addr = '0;
    logic [63:0] wdata = '0;
    logic [63:0] rdata;
    logic        rvalid;
    logic        err;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;
    logic [7:0] model [BYTES];

    always #2 clk = ~clk;

    sized_row_mem #(.ADDR_W(AW)) i_sized_row_mem (
        .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .size_i(size),
        .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .rvalid_o(rvalid), .err_o(err)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit is_bad(input logic [1:0] sz, input logic [AW-1:0] a);
        int n = 1 << sz;
        return (int'(a) % n) != 0;
    endfunction

    function automatic logic [63:0] model_read(input logic [1:0] sz, input logic [AW-1:0] a);
        logic [63:0] v = '0;
        if (is_bad(sz, a)) return '0;
        for (int i = 0; i < (1 << sz); i++) v[8*i +: 8] = model[int'(a) + i];
        return v;
    endfunction

    // one access: drive at negedge, check err, clock, check outputs at next negedge
    task automatic access(input bit w, input logic [1:0] sz, input logic [AW-1:0] a,
                          input logic [63:0] d, input logic [63:0] exp_rd, input string tag);
        bit bad = is_bad(sz, a);
        req = 1'b1; we = w; size = sz; addr = a; wdata = d;
        #1;
        check(err == bad, {tag, " R2 err"}, 64'(err), 64'(bad));
        @(posedge clk);
        @(negedge clk);
        req = 1'b0; we = 1'b0;
        check(rvalid == !w, {tag, " R7 rvalid"}, 64'(rvalid), 64'(!w));
        if (!w) begin
            check(rdata == exp_rd, {tag, " rdata"}, rdata, exp_rd);
        end else if (!bad) begin
            for (int i = 0; i < (1 << sz); i++) model[int'(a) + i] = d[8*i +: 8];
        end
    endtask

    task automatic rd(input logic [1:0] sz, input logic [AW-1:0] a, input string tag);
        access(1'b0, sz, a, 64'h0, model_read(sz, a), tag);
    endtask

    task automatic wr(input logic [1:0] sz, input logic [AW-1:0] a, input logic [63:0] d, input string tag);
        access(1'b1, sz, a, d, 64'h0, tag);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(rvalid == 1'b0, "R9 rvalid in reset", 64'(rvalid), 64'h0);
        check(rdata == '0, "R9 rdata in reset", rdata, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(rvalid == 1'b0, "R9 rvalid after reset", 64'(rvalid), 64'h0);
    endtask

    task automatic t_fill;
        for (int r = 0; r < BYTES / 8; r++) begin
            wr(2'b11, AW'(r * 8), {32'hC0DE_0000 + 32'(r), 32'h1234_0000 + 32'(r)}, "R1 fill");
        end
    endtask

    task automatic t_endian;
        wr(2'b11, AW'(0), 64'h8877_6655_4433_2211, "R8 quad write");
        rd(2'b11, AW'(0), "R8 read next cycle");
        check(rdata == 64'h8877_6655_4433_2211, "R8 quad value", rdata, 64'h8877_6655_4433_2211);
        for (int i = 0; i < 8; i++) begin
            rd(2'b00, AW'(i), "R5 byte lane");
            check(rdata == 64'(8'h11 * (i + 1)), "R5 byte order", rdata, 64'(8'h11 * (i + 1)));
        end
        rd(2'b01, AW'(2), "R6 half read");
        check(rdata == 64'h4433, "R5 R6 half value", rdata, 64'h4433);
        rd(2'b10, AW'(4), "R6 word read");
        check(rdata == 64'h8877_6655, "R5 R6 word value", rdata, 64'h8877_6655);
    endtask

    task automatic t_partial_writes;
        wr(2'b00, AW'(8'h13), 64'hFFFF_FFFF_FFFF_FFAB, "R1 byte write");
        rd(2'b11, AW'(8'h10), "R1 byte neighbours");
        wr(2'b01, AW'(8'h16), 64'hEEEE_EEEE_EEEE_BEEF, "R1 half write");
        rd(2'b11, AW'(8'h10), "R1 half neighbours");
        wr(2'b10, AW'(8'h1C), 64'hDDDD_DDDD_CAFE_F00D, "R1 word write");
        rd(2'b11, AW'(8'h18), "R1 word neighbours");
        rd(2'b10, AW'(8'h1C), "R5 word readback");
        check(rdata == 64'hCAFE_F00D, "R5 word written value", rdata, 64'hCAFE_F00D);
    endtask

    task automatic t_misaligned;
        for (int sz = 1; sz < 4; sz++) begin
            for (int off = 1; off < 8; off++) begin
                if (off % (1 << sz) != 0) begin
                    wr(2'(sz), AW'(8'h40 + off), 64'hBAD0_BAD1_BAD2_BAD3, "R3 bad write");
                    rd(2'b11, AW'(8'h40), "R3 row intact");
                    rd(2'(sz), AW'(8'h40 + off), "R4 bad read zero");
                end
            end
        end
        for (int sz = 0; sz < 4; sz++) begin
            for (int off = 0; off < 8; off++) begin
                rd(2'(sz), AW'(8'h48 + off), "R2 sweep");
            end
        end
    endtask

    task automatic t_idle;
        @(negedge clk);
        req = 1'b0; we = 1'b1; size = 2'b11; addr = AW'(8'h50); wdata = 64'hFFFF_FFFF_FFFF_FFFF;
        #1;
        check(err == 1'b0, "R10 idle err", 64'(err), 64'h0);
        @(posedge clk);
        addr = AW'(8'h51);
        #1;
        check(err == 1'b0, "R10 idle misaligned err", 64'(err), 64'h0);
        @(negedge clk);
        check(rvalid == 1'b0, "R7 idle rvalid", 64'(rvalid), 64'h0);
        we = 1'b0;
        rd(2'b11, AW'(8'h50), "R10 idle no write");
    endtask

    task automatic t_random;
        for (int k = 0; k < 400; k++) begin
            logic [1:0]    sz = 2'($urandom_range(0, 3));
            logic [AW-1:0] a  = AW'($urandom_range(0, BYTES - 1));
            logic [63:0]   d  = {$urandom, $urandom};
            a = AW'((int'(a) >> sz) << sz);
            if ($urandom_range(0, 1) == 1) wr(sz, a, d, "R1 random write");
            else rd(sz, a, "R5 R6 random read");
        end
    endtask

    initial begin
        t_reset();
        t_fill();
        t_endian();
        t_partial_writes();
        t_misaligned();
        t_idle();
        t_random();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not complete actual=hung expected=done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule